// File: doc/BRIEF.md
# Cyclic-Shift Load-Balanced Cell Switch

This block moves fixed-size cells between N ports through two switching stages with no scheduler. Both stages follow the same traffic-independent cyclic-shift schedule, driven only by a slot counter. The first stage hands each arriving cell, in its arrival slot, to the intermediate port it is wired to in that slot. The destination plays no part in that choice.

Each intermediate port holds one FIFO per final output, N by N in all. The second stage then links each intermediate port to one output per slot. It forwards the head cell of the matching queue, so every queue gets exactly one service chance every N slots. All buffering sits between the stages. A cell that finds its queue full is discarded, and the discard is counted against the input port it arrived on.

Ports are numbered from 0. In slot t, a stage links its port i to port (i + t) mod N. Both stages use one cell time per clock.

Top module: `lbs_switch`

## Requirements
- R1: `slot` is 0 after reset and advances by one every clock, wrapping from N-1 to 0.
- R2: A valid cell on input i during slot t is placed at intermediate port (i + t) mod N in that same slot, whatever its destination.
- R3: At the intermediate port, the cell is queued in the FIFO for the output given by `in_dest`. It can only ever appear on that output.
- R4: In slot t, intermediate port k offers the head of its FIFO for output (k + t) mod N. When that FIFO is non-empty, the head cell is removed and shown on `out_valid`/`out_data` of output (k + t) mod N in the cycle after slot t.
- R5: When the FIFO offered to an output in slot t is empty, that output has `out_valid` low in the following cycle.
- R6: Cells leave each FIFO in the order they entered it. A cell that arrives in slot t can leave no earlier than its next service slot.
- R7: Each FIFO holds `VOQ_DEPTH` cells. A cell is discarded when its FIFO already holds `VOQ_DEPTH` cells at the start of the slot, even if that FIFO is served in the same slot. The discard adds one to `drop_count` of the arriving input port, which wraps modulo 2^`DROP_W`.
- R8: During and right after reset, all `out_valid` bits are low and every `drop_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cell time per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | N_PORTS | Cell present on each input |
| in_dest | input | N_PORTS x DEST_W | Final output of each arriving cell |
| in_data | input | N_PORTS x PAYLOAD_W | Payload of each arriving cell |
| out_valid | output | N_PORTS | Cell present on each output |
| out_data | output | N_PORTS x PAYLOAD_W | Payload of each departing cell |
| slot | output | DEST_W | Current slot number, modulo N_PORTS |
| drop_count | output | N_PORTS x DROP_W | Discarded cells per input port |

## Verification
A behavioural model holds one queue per intermediate/output pair and predicts every output in every cycle. It is driven with four kinds of traffic:

- A lone cell. This pins the slot at which the shift sends it and the exact cycle it departs.
- A hotspot, with every input aimed at one output. This fills the queues for that output, so the full-queue discard and the per-input counters are exercised, including a discard into a queue that is being served.
- A rotating permutation that spreads load evenly. This shows that occupancy never changes the schedule.
- Pseudo-random sparse traffic followed by a drain. This exposes ordering errors within a queue and any cell sent to the wrong output.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

    // Sum of two port indices on a ring of n ports.
    function automatic int unsigned ring_add(int unsigned a, int unsigned b, int unsigned n);
        return (a + b) % n;
    endfunction

endpackage

// File: rtl/lbs_slot_counter.sv
module lbs_slot_counter #(
    parameter int N  = 4,
    parameter int SW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [SW-1:0] slot
);
    typedef struct packed {
        logic [SW-1:0] slot;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.slot == SW'(N - 1)) st_d.slot = '0;
        else                         st_d.slot = st_q.slot + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign slot = st_q.slot;

    // R1: one step per cell time, wrapping at N
    a_r1_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (slot == (($past(slot) == SW'(N - 1)) ? '0 : $past(slot) + 1'b1)));

endmodule

// File: rtl/lbs_cyclic_shift.sv
module lbs_cyclic_shift
    import lbs_pkg::*;
#(
    parameter int N  = 4,
    parameter int W  = 8,
    parameter int SW = 2
) (
    input  logic [N-1:0][W-1:0] src,
    input  logic [SW-1:0]       slot,
    output logic [N-1:0][W-1:0] dst
);
    // Source i reaches destination (i + slot) mod N, so destination j
    // takes source (j - slot) mod N.
    for (genvar j = 0; j < N; j++) begin : g_lane
        always_comb begin
            dst[j] = src[ring_add(j, N - int'(slot), N)];
        end
    end

endmodule

// File: rtl/lbs_voq.sv
module lbs_voq #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] wdata,
    output logic         full,
    output logic         empty,
    output logic [W-1:0] head
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wp;
        logic [PTR_W-1:0]        rp;
        logic [CNT_W-1:0]        cnt;
    } state_t;

    state_t st_d, st_q;
    logic   do_push, do_pop;

    assign full    = (st_q.cnt == CNT_W'(DEPTH));
    assign empty   = (st_q.cnt == '0);
    assign head    = st_q.mem[st_q.rp];
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_comb begin
        st_d = st_q;
        if (do_push) begin
            st_d.mem[st_q.wp] = wdata;
            st_d.wp = (st_q.wp == PTR_W'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
        end
        if (do_pop) begin
            st_d.rp = (st_q.rp == PTR_W'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7: occupancy never exceeds the configured depth
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH));
    // R4: the server only draws from a queue that holds a cell
    a_r4_pop_has_cell: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    // R6: an accepted cell without a service is still held next slot
    a_r6_push_held: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full && !pop) |=> !empty);

endmodule

// File: rtl/lbs_switch.sv
module lbs_switch
    import lbs_pkg::*;
#(
    parameter int N_PORTS   = 4,
    parameter int PAYLOAD_W = 8,
    parameter int VOQ_DEPTH = 4,
    parameter int DROP_W    = 8,
    localparam int DEST_W   = $clog2(N_PORTS)
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [N_PORTS-1:0]                   in_valid,
    input  logic [N_PORTS-1:0][DEST_W-1:0]       in_dest,
    input  logic [N_PORTS-1:0][PAYLOAD_W-1:0]    in_data,
    output logic [N_PORTS-1:0]                   out_valid,
    output logic [N_PORTS-1:0][PAYLOAD_W-1:0]    out_data,
    output logic [DEST_W-1:0]                    slot,
    output logic [N_PORTS-1:0][DROP_W-1:0]       drop_count
);
    localparam int CELL_W = 1 + DEST_W + PAYLOAD_W;
    localparam int SRV_W  = 1 + PAYLOAD_W;

    logic [N_PORTS-1:0][CELL_W-1:0]                  arr_cell, mid_cell;
    logic [N_PORTS-1:0][N_PORTS-1:0]                 voq_push, voq_pop, voq_full, voq_empty;
    logic [N_PORTS-1:0][N_PORTS-1:0][PAYLOAD_W-1:0]  voq_head;
    logic [N_PORTS-1:0][DEST_W-1:0]                  serve_sel;
    logic [N_PORTS-1:0][SRV_W-1:0]                   served, out_cell;
    logic [N_PORTS-1:0]                              dropped;

    typedef struct packed {
        logic [N_PORTS-1:0]                valid;
        logic [N_PORTS-1:0][PAYLOAD_W-1:0] data;
        logic [N_PORTS-1:0][DROP_W-1:0]    drops;
    } state_t;

    state_t st_d, st_q;

    lbs_slot_counter #(.N(N_PORTS), .SW(DEST_W)) u_slot (
        .clk(clk), .rst_n(rst_n), .slot(slot)
    );

    // Stage one: spread arrivals by the current shift
    always_comb begin
        for (int i = 0; i < N_PORTS; i++) begin
            arr_cell[i] = {in_valid[i], in_dest[i], in_data[i]};
        end
    end

    lbs_cyclic_shift #(.N(N_PORTS), .W(CELL_W), .SW(DEST_W)) u_stage1 (
        .src(arr_cell), .slot(slot), .dst(mid_cell)
    );

    // Per-destination queues at each intermediate port
    for (genvar k = 0; k < N_PORTS; k++) begin : g_mid
        always_comb begin
            serve_sel[k] = DEST_W'(ring_add(k, int'(slot), N_PORTS));
        end
        for (genvar d = 0; d < N_PORTS; d++) begin : g_dst
            assign voq_push[k][d] = mid_cell[k][CELL_W-1]
                                 && (mid_cell[k][PAYLOAD_W +: DEST_W] == DEST_W'(d));
            assign voq_pop[k][d]  = (serve_sel[k] == DEST_W'(d)) && !voq_empty[k][d];

            lbs_voq #(.DEPTH(VOQ_DEPTH), .W(PAYLOAD_W)) u_voq (
                .clk(clk), .rst_n(rst_n),
                .push(voq_push[k][d]), .pop(voq_pop[k][d]),
                .wdata(mid_cell[k][PAYLOAD_W-1:0]),
                .full(voq_full[k][d]), .empty(voq_empty[k][d]),
                .head(voq_head[k][d])
            );
        end
        always_comb begin
            served[k] = {!voq_empty[k][serve_sel[k]], voq_head[k][serve_sel[k]]};
        end
    end

    // Stage two: same shift, from intermediate ports to outputs
    lbs_cyclic_shift #(.N(N_PORTS), .W(SRV_W), .SW(DEST_W)) u_stage2 (
        .src(served), .slot(slot), .dst(out_cell)
    );

    // Discard detection, seen from the arriving input
    always_comb begin
        for (int i = 0; i < N_PORTS; i++) begin
            dropped[i] = in_valid[i]
                      && voq_full[ring_add(i, int'(slot), N_PORTS)][in_dest[i]];
        end
    end

    always_comb begin
        st_d = st_q;
        for (int o = 0; o < N_PORTS; o++) begin
            st_d.valid[o] = out_cell[o][PAYLOAD_W];
            st_d.data[o]  = out_cell[o][PAYLOAD_W-1:0];
        end
        for (int i = 0; i < N_PORTS; i++) begin
            if (dropped[i]) st_d.drops[i] = st_q.drops[i] + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid  = st_q.valid;
    assign out_data   = st_q.data;
    assign drop_count = st_q.drops;

    for (genvar i = 0; i < N_PORTS; i++) begin : g_chk
        // R7: a discard adds exactly one to the arriving port's counter
        a_r7_drop_step: assert property (@(posedge clk) disable iff (!rst_n)
            dropped[i] |=> (drop_count[i] == $past(drop_count[i]) + 1'b1));
        // R7: no discard leaves the counter untouched
        a_r7_drop_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!dropped[i] && $past(rst_n)) |=> $stable(drop_count[i]));
    end

endmodule

// File: tb/lbs_switch_test.sv
module lbs_switch_test;
    localparam int N  = 4;
    localparam int DW = 2;
    localparam int PW = 8;
    localparam int DEPTH = 4;
    localparam int DRW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0]         in_valid = '0;
    logic [N-1:0][DW-1:0] in_dest  = '0;
    logic [N-1:0][PW-1:0] in_data  = '0;
    logic [N-1:0]          out_valid;
    logic [N-1:0][PW-1:0]  out_data;
    logic [DW-1:0]         slot;
    logic [N-1:0][DRW-1:0] drop_count;

    int checks = 0;
    int fails  = 0;
    int mt     = 0;
    logic [PW-1:0] mq [N][N][$];
    int  exp_drop [N];
    bit  exp_v    [N];
    logic [PW-1:0] exp_d [N];
    int  lfsr = 16'hACE1;
    int  seq  = 0;

    always #5 clk = ~clk;

    lbs_switch #(.N_PORTS(N), .PAYLOAD_W(PW), .VOQ_DEPTH(DEPTH), .DROP_W(DRW)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest),
        .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
        .slot(slot), .drop_count(drop_count)
    );

    task automatic check(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, expv, $time);
        end
    endtask

    // One slot: called at a negedge with inputs already set
    task automatic run_slot();
        bit full_at [N];
        check(slot == DW'(mt), "R1 slot", int'(slot), mt);
        for (int i = 0; i < N; i++) begin
            full_at[i] = in_valid[i] && (mq[(i + mt) % N][in_dest[i]].size() >= DEPTH);
        end
        for (int o = 0; o < N; o++) begin
            int k = (o - mt + N) % N;
            exp_v[o] = (mq[k][o].size() > 0);
            if (exp_v[o]) exp_d[o] = mq[k][o].pop_front();
        end
        for (int i = 0; i < N; i++) begin
            if (in_valid[i]) begin
                if (full_at[i]) exp_drop[i] = (exp_drop[i] + 1) % (1 << DRW);
                else mq[(i + mt) % N][in_dest[i]].push_back(in_data[i]);
            end
        end
        @(posedge clk);
        @(negedge clk);
        for (int o = 0; o < N; o++) begin
            check(out_valid[o] == exp_v[o], "R4/R5 out_valid", int'(out_valid[o]), int'(exp_v[o]));
            if (exp_v[o])
                check(out_data[o] == exp_d[o], "R2 R3 R6 out_data", int'(out_data[o]), int'(exp_d[o]));
        end
        for (int i = 0; i < N; i++) begin
            check(drop_count[i] == DRW'(exp_drop[i]), "R7 drop_count", int'(drop_count[i]), exp_drop[i]);
        end
        mt = (mt + 1) % N;
    endtask

    function automatic logic [PW-1:0] tag(int src);
        seq++;
        return PW'((src << 6) | (seq & 63));
    endfunction

    task automatic idle();
        in_valid = '0;
        run_slot();
    endtask

    initial begin
        for (int i = 0; i < N; i++) exp_drop[i] = 0;
        repeat (3) @(negedge clk);
        // R8: reset state
        check(out_valid == '0, "R8 out_valid in reset", int'(out_valid), 0);
        check(drop_count == '0, "R8 drop_count in reset", int'(drop_count[0]), 0);
        check(slot == '0, "R1 slot in reset", int'(slot), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // one edge has passed with reset released: slot already 1
        check(out_valid == '0, "R8 out_valid after reset", int'(out_valid), 0);
        mt = 1;

        // Lone cell: input 1 to output 2 (R2, R4 timing)
        in_valid = '0; in_valid[1] = 1'b1; in_dest[1] = 2; in_data[1] = tag(1);
        run_slot();
        repeat (6) idle();

        // Hotspot: every input to output 0 (R7 discards, served-while-full)
        for (int c = 0; c < 16; c++) begin
            for (int i = 0; i < N; i++) begin
                in_valid[i] = 1'b1; in_dest[i] = 0; in_data[i] = tag(i);
            end
            run_slot();
        end
        repeat (20) idle();

        // Rotating permutation, uniform load
        for (int c = 0; c < 40; c++) begin
            for (int i = 0; i < N; i++) begin
                in_valid[i] = 1'b1; in_dest[i] = DW'((i + c) % N); in_data[i] = tag(i);
            end
            run_slot();
        end

        // Pseudo-random sparse traffic
        for (int c = 0; c < 300; c++) begin
            for (int i = 0; i < N; i++) begin
                lfsr = ((lfsr >> 1) ^ ((lfsr & 1) != 0 ? 16'hB400 : 0)) & 16'hFFFF;
                in_valid[i] = lfsr[0] & lfsr[3];
                in_dest[i]  = lfsr[5:4];
                in_data[i]  = tag(i);
            end
            run_slot();
        end

        // Drain
        repeat (30) idle();
        for (int k = 0; k < N; k++)
            for (int d = 0; d < N; d++)
                check(mq[k][d].size() == 0, "R4 model drained", mq[k][d].size(), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #1_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule